// File: doc/BRIEF.md
# Sequential Two-Product Difference Datapath with Coefficient Bank

The block evaluates c = (a*v1 + v3) - (b*v2 + v4) on signed operands. Two operands, a and then b, arrive one after the other on one input bus. Four stored coefficients are kept in a small single-port bank, and the result leaves on one output bus together with a one-cycle valid pulse. Only one multiplier, one adder and one subtractor are present, so a five-state controller time-shares them. The controller also walks the bank in ascending address order, one read per cycle, which gives a sequential burst of four reads.

The controller states are named as follows. S_IDLE waits, and when in_valid is high it takes a, reads address 0 (v1) and forms a*v1. S_MUL_B takes b, reads address 1 (v2) and forms b*v2. S_ADD_V3 reads address 2 (v3) and adds it to the first product. S_ADD_V4 reads address 3 (v4) and adds it to the second product. S_SUB subtracts the second sum from the first. The transitions are: S_IDLE to S_MUL_B on in_valid, otherwise stay in S_IDLE; S_MUL_B to S_ADD_V3, S_ADD_V3 to S_ADD_V4, S_ADD_V4 to S_SUB and S_SUB to S_IDLE, each taken unconditionally. The coefficients are written through a separate load port, and only while the block is idle.

Top module: `mac_seq_core`

## Requirements
- R1: out_c equals (a*v1 + v3) - (b*v2 + v4), computed exactly as signed values. The output is OW = 2*DW+2 bits wide, so no input combination can overflow it.
- R2: A computation starts when idle is high and in_valid is high; in_data in that cycle is a. On the following cycle in_data is taken as b, whatever the value of in_valid.
- R3: out_valid is high for exactly one cycle. It rises 5 cycles after the clock edge that accepts a, and it is low in the four cycles between that edge and the pulse.
- R4: idle is low from the cycle after a is accepted until the out_valid cycle. In that cycle idle is high again, so a new a may be accepted there. in_valid is ignored while idle is low.
- R5: v1, v2, v3 and v4 sit at bank addresses 0, 1, 2 and 3. Each computation reads them one per cycle, in ascending address order, starting in the cycle a is accepted.
- R6: A load (ld_we high) while idle is high writes ld_data to address ld_addr. A load while idle is low is dropped, and the bank keeps its previous contents.
- R7: When a load and a start fall in the same cycle, the computation uses the bank contents from before the load, and the load still takes effect for later computations.
- R8: After reset idle is 1, out_valid is 0 and out_c is 0. out_c holds the last result until the next out_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Start request carrying a; sampled only while idle |
| in_data | input | DW | Operand bus: a in the start cycle, b in the cycle after |
| ld_we | input | 1 | Coefficient write enable |
| ld_addr | input | 2 | Coefficient address (0..3 = v1..v4) |
| ld_data | input | DW | Coefficient value, signed |
| idle | output | 1 | High when a new computation may start |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_c | output | OW | Signed result, held between pulses |

## Verification
The bench goes after the edges of the schedule. These are: starts back to back in the pulse cycle, in_valid held high while busy, loads issued during a computation, and a load in the same cycle as a start. A controller that re-sampled in_valid while busy would start a spurious run and shift later pulses. A bank that accepted writes while busy would corrupt the coefficient read in a later step, and the next result would then differ. Full-scale operands (-32768 times -32768 with maximal addends) show whether the intermediate widths truncate or drop the sign. Random operands and coefficients, paired with a bench model, catch an address order or an adder source that is swapped.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

    localparam int unsigned NCOEF  = 4;
    localparam int unsigned CA_W   = $clog2(NCOEF);

    typedef enum logic [2:0] {
        S_IDLE,
        S_MUL_B,
        S_ADD_V3,
        S_ADD_V4,
        S_SUB
    } sched_state_t;

    typedef struct packed {
        logic            mul_en;
        logic            mul_dst;   // 0: first product, 1: second product
        logic            add_en;
        logic            add_dst;   // 0: first sum, 1: second sum
        logic            sub_en;
        logic [CA_W-1:0] rd_addr;
    } dp_ctl_t;

endpackage

// File: rtl/coef_bank.sv
module coef_bank
    import mac_seq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [CA_W-1:0]        waddr,
    input  logic signed [DW-1:0]   wdata,
    input  logic [CA_W-1:0]        raddr,
    output logic signed [DW-1:0]   rdata
);

    logic signed [DW-1:0] cells [NCOEF];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // single read port, combinational
    assign rdata = cells[raddr];

endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
    import mac_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output sched_state_t  state,
    output dp_ctl_t       ctl,
    output logic          idle,
    output logic          out_valid
);

    sched_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // result strobe follows the subtract step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= (state == S_SUB);
        end
    end

    // next state and datapath controls
    always_comb begin
        nxt         = state;
        ctl         = '0;
        idle        = 1'b0;
        unique case (state)
            S_IDLE: begin
                idle        = 1'b1;
                ctl.rd_addr = CA_W'(0);
                if (in_valid) begin
                    ctl.mul_en  = 1'b1;
                    ctl.mul_dst = 1'b0;
                    nxt         = S_MUL_B;
                end
            end
            S_MUL_B: begin
                ctl.rd_addr = CA_W'(1);
                ctl.mul_en  = 1'b1;
                ctl.mul_dst = 1'b1;
                nxt         = S_ADD_V3;
            end
            S_ADD_V3: begin
                ctl.rd_addr = CA_W'(2);
                ctl.add_en  = 1'b1;
                ctl.add_dst = 1'b0;
                nxt         = S_ADD_V4;
            end
            S_ADD_V4: begin
                ctl.rd_addr = CA_W'(3);
                ctl.add_en  = 1'b1;
                ctl.add_dst = 1'b1;
                nxt         = S_SUB;
            end
            S_SUB: begin
                ctl.sub_en  = 1'b1;
                nxt         = S_IDLE;
            end
            default: begin
                nxt         = S_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/mac_seq_dp.sv
module mac_seq_dp
    import mac_seq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [DW-1:0]   in_data,
    input  logic signed [DW-1:0]   coef,
    input  dp_ctl_t                ctl,
    output logic signed [2*DW+1:0] out_c
);

    localparam int unsigned PW = 2 * DW;       // product width
    localparam int unsigned SW = PW + 1;       // sum width
    localparam int unsigned OW = PW + 2;       // difference width

    logic signed [PW-1:0] x1_q, x2_q;
    logic signed [SW-1:0] y1_q, y2_q;
    logic signed [OW-1:0] c_q;

    logic signed [PW-1:0] op_a, op_c, prod;
    logic signed [PW-1:0] add_src;
    logic signed [SW-1:0] sum;
    logic signed [OW-1:0] diff;

    // shared multiplier
    assign op_a = PW'(in_data);
    assign op_c = PW'(coef);
    assign prod = op_a * op_c;

    // shared adder: source product follows the destination sum
    assign add_src = ctl.add_dst ? x2_q : x1_q;
    assign sum     = SW'(add_src) + SW'(coef);

    // subtractor
    assign diff = OW'(y1_q) - OW'(y2_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1_q <= '0;
            x2_q <= '0;
            y1_q <= '0;
            y2_q <= '0;
            c_q  <= '0;
        end else begin
            if (ctl.mul_en && !ctl.mul_dst) x1_q <= prod;
            if (ctl.mul_en &&  ctl.mul_dst) x2_q <= prod;
            if (ctl.add_en && !ctl.add_dst) y1_q <= sum;
            if (ctl.add_en &&  ctl.add_dst) y2_q <= sum;
            if (ctl.sub_en)                 c_q  <= diff;
        end
    end

    assign out_c = c_q;

endmodule

// File: rtl/mac_seq_core.sv
module mac_seq_core
    import mac_seq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   in_data,
    input  logic                   ld_we,
    input  logic [1:0]             ld_addr,
    input  logic signed [DW-1:0]   ld_data,
    output logic                   idle,
    output logic                   out_valid,
    output logic signed [2*DW+1:0] out_c
);

    sched_state_t         cur_state;
    dp_ctl_t              ctl;
    logic [CA_W-1:0]      rd_addr;
    logic signed [DW-1:0] coef;
    logic                 bank_we;

    // loads are honoured only while no computation runs
    assign bank_we = ld_we && idle;
    assign rd_addr = ctl.rd_addr;

    mac_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .state     (cur_state),
        .ctl       (ctl),
        .idle      (idle),
        .out_valid (out_valid)
    );

    coef_bank #(.DW(DW)) u_bank (
        .clk   (clk),
        .we    (bank_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (rd_addr),
        .rdata (coef)
    );

    mac_seq_dp #(.DW(DW)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (in_data),
        .coef    (coef),
        .ctl     (ctl),
        .out_c   (out_c)
    );

endmodule

// File: rtl/mac_seq_chk.sv
module mac_seq_chk
    import mac_seq_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         idle,
    input logic         out_valid,
    input sched_state_t state,
    input logic [1:0]   rd_addr
);

    // R3
    latency_five_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && in_valid) |-> ##5 out_valid);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && in_valid) |=> !idle);

    // R4
    idle_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> idle);

    // R5
    burst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MUL_B || state == S_ADD_V3 || state == S_ADD_V4)
        |-> rd_addr == 2'($past(rd_addr) + 2'd1));

endmodule

bind mac_seq_core mac_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .idle      (idle),
    .out_valid (out_valid),
    .state     (cur_state),
    .rd_addr   (rd_addr)
);

// File: tb/mac_seq_core_test.sv
`timescale 1ns/1ps
module mac_seq_core_test;

    localparam int DW = 16;
    localparam int OW = 2 * DW + 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 ld_we = 1'b0;
    logic [1:0]           ld_addr = '0;
    logic signed [DW-1:0] ld_data = '0;
    logic                 idle;
    logic                 out_valid;
    logic signed [OW-1:0] out_c;

    int n_chk = 0;
    int n_bad = 0;
    logic signed [DW-1:0] shadow [4];

    always #2.5 clk = ~clk;

    mac_seq_core #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .idle(idle), .out_valid(out_valid), .out_c(out_c)
    );

    function automatic logic signed [OW-1:0] model(input logic signed [DW-1:0] a,
                                                   input logic signed [DW-1:0] b);
        logic signed [OW-1:0] p1, p2;
        p1 = OW'(a) * OW'(shadow[0]) + OW'(shadow[2]);
        p2 = OW'(b) * OW'(shadow[1]) + OW'(shadow[3]);
        return p1 - p2;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic signed [OW-1:0] act, input logic signed [OW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // caller is just after a negedge; write takes effect at the next edge
    task automatic load(input int addr, input logic signed [DW-1:0] val);
        ld_we = 1'b1; ld_addr = 2'(addr); ld_data = val;
        @(negedge clk);
        ld_we = 1'b0;
        shadow[addr] = val;
    endtask

    // mode 0: plain, 1: in_valid held high while busy,
    // 2: load issued while busy, 3: load to address 0 in the start cycle
    task automatic run(input logic signed [DW-1:0] a, input logic signed [DW-1:0] b,
                       input int mode, input logic signed [DW-1:0] newv);
        logic signed [OW-1:0] exp;
        bit lat_ok;
        exp = model(a, b);
        check(idle == 1'b1, "R4 idle before start", OW'(idle), 1);
        in_valid = 1'b1; in_data = a;
        if (mode == 3) begin
            ld_we = 1'b1; ld_addr = 2'd0; ld_data = newv;
        end
        @(negedge clk);                                  // N1
        ld_we = 1'b0;
        if (mode == 3) shadow[0] = newv;
        in_data  = b;                                    // R2: b taken regardless of in_valid
        in_valid = (mode == 1);
        check(idle == 1'b0, "R4 busy after accept", OW'(idle), 0);
        lat_ok = (out_valid == 1'b0);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            in_data = DW'($urandom);
            if (mode == 2 && k == 2) begin
                ld_we = 1'b1; ld_addr = 2'd1; ld_data = ~shadow[1];
            end else begin
                ld_we = 1'b0;
            end
            lat_ok = lat_ok && !out_valid && !idle;
        end
        @(negedge clk);                                  // N5
        ld_we = 1'b0;
        in_valid = 1'b0;
        check(lat_ok, "R3 no early pulse", OW'(lat_ok), 1);
        check(out_valid == 1'b1, "R3 pulse at cycle 5", OW'(out_valid), 1);
        check(out_c == exp, "R1 result", out_c, exp);
        check(idle == 1'b1, "R4 idle in pulse cycle", OW'(idle), 1);
    endtask

    task automatic after_pulse(input logic signed [OW-1:0] last);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 pulse one cycle", OW'(out_valid), 0);
        check(out_c == last, "R8 result held", out_c, last);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic signed [OW-1:0] last;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(idle == 1'b1, "R8 reset idle", OW'(idle), 1);
        check(out_valid == 1'b0, "R8 reset out_valid", OW'(out_valid), 0);
        check(out_c == '0, "R8 reset out_c", out_c, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: loads while idle; R5: distinct values expose address mapping
        load(0, 16'sd3); load(1, -16'sd5); load(2, 16'sd7); load(3, 16'sd11);
        run(16'sd2, 16'sd3, 0, 0);                       // 6+7 - (-15+11) = 17
        check(out_c == 34'sd17, "R5 address mapping", out_c, 17);
        last = out_c;
        after_pulse(last);

        // R1: full-scale operands
        load(0, -16'sd32768); load(1, 16'sd32767); load(2, 16'sd32767); load(3, -16'sd32768);
        run(-16'sd32768, -16'sd32768, 0, 0);
        last = out_c;
        after_pulse(last);
        run(16'sd32767, 16'sd32767, 0, 0);
        after_pulse(out_c);

        // R4: back-to-back start in the pulse cycle, in_valid ignored while busy
        load(0, 16'sd9); load(1, 16'sd4); load(2, -16'sd100); load(3, 16'sd50);
        run(16'sd10, -16'sd6, 1, 0);
        run(-16'sd7, 16'sd8, 0, 0);
        after_pulse(out_c);

        // R6: load while busy dropped
        run(16'sd1, 16'sd1, 2, 0);
        after_pulse(out_c);
        run(16'sd0, 16'sd1, 0, 0);                       // exposes v2, v3, v4
        check(out_c == model(16'sd0, 16'sd1), "R6 busy load dropped", out_c, model(16'sd0, 16'sd1));
        after_pulse(out_c);

        // R7: load in start cycle uses old v1, new v1 afterwards
        run(16'sd5, 16'sd0, 3, 16'sd1234);
        after_pulse(out_c);
        run(16'sd5, 16'sd0, 0, 0);
        check(out_c == 34'sd6170 - 34'sd50 + (-34'sd100), "R7 new v1 applied",
              out_c, 34'sd6170 - 34'sd50 + (-34'sd100));
        after_pulse(out_c);

        // random operands and coefficients
        for (int i = 0; i < 60; i++) begin
            if (($urandom % 3) == 0) begin
                for (int j = 0; j < 4; j++) load(j, DW'($urandom));
            end
            run(DW'($urandom), DW'($urandom), int'($urandom % 2), 0);
            if (($urandom % 2) == 0) after_pulse(out_c);
        end

        @(negedge clk);
        summary();
        $finish;
    end

endmodule